// File: doc/BRIEF.md
# Load Address Generation Unit

This unit works out, for one load, the byte address sent to memory and the value the pointer register should take afterwards. The address can come from eight addressing modes: a base register plus an offset, a scaled index added to an absolute constant, an absolute address that is also copied into the pointer, three plain post-increment forms (by immediate, by modifier register, and with bit-reversed addressing), and two circular-buffer post-increment forms. The loaded data itself, its sign or zero extension and the memory access are handled elsewhere.

The unit is purely combinational. A pipeline stage presents the mode and the operand registers, and in the same cycle reads back the effective address, the next pointer value and a write-back enable that tells the register file whether to update the pointer. The bit-reversed mode suits radix-2 transform buffers aligned to 64 KiB. The circular modes keep a pointer inside a buffer given by a start address and a length. One of them takes its increment from the immediate. The other takes a signed increment, packed next to the length in the modifier register, and scales it by the access size.

Top module: `load_agu`

## Requirements
- R1: Mode 0 (offset): the effective address is base + immediate (modulo 2^32), write-back enable is 0, and the pointer output equals the base input.
- R2: Mode 1 (scaled index): the effective address is (index << shift) + immediate, where the immediate carries the 32-bit absolute constant. Write-back enable is 0 and the pointer output equals the base.
- R3: Mode 2 (absolute set): the effective address and the pointer output both equal the immediate, and write-back enable is 1.
- R4: Mode 3 (post-increment by immediate): the effective address is the old base and the pointer output is base + immediate.
- R5: Mode 4 (post-increment by modifier): the effective address is the old base and the pointer output is base + modifier.
- R6: Mode 5 (bit-reversed): bits 31:16 of the effective address equal those of the base, and bits 15:0 are base bits 15:0 in reversed order (address bit i = base bit 15-i). The pointer output is base + modifier. With modifier 0x2000 and a 64 KiB-aligned start, four chained accesses reach offsets 0, 4, 2, 6.
- R7: Mode 6 (circular by immediate): the buffer length is modifier bits 16:0 and the start is the circular-start input. The pointer output is start + ((base - start + immediate) mod length). The effective address is the old base. Length 6 with increment 2 returns to offset 0 on the fourth access.
- R8: Mode 7 (circular by register): the increment is the signed 7-bit field in modifier bits 23:17, multiplied by 2^size, where size is 0 to 3 for 1, 2, 4 or 8 bytes. The length is modifier bits 16:0, and the wrap follows R7. Length 8, increment 2 and a 2-byte access give offsets 0, 4, 0, 4.
- R9: In both circular modes a negative increment that takes the offset below zero wraps by adding the length. This requires the length to be nonzero, the old offset to be below the length, and the increment magnitude to be no larger than the length.
- R10: Write-back enable is 1 exactly for modes 2 through 7 and 0 for modes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 3 | Addressing mode, encoded as in R1 to R8 |
| baseReg | input | 32 | Base or pointer register value |
| indexReg | input | 32 | Index register for the scaled-index mode |
| immVal | input | 32 | Immediate offset, increment or absolute constant |
| shiftAmt | input | 2 | Left shift applied to the index |
| modReg | input | 32 | Modifier register (increment, or packed increment and length) |
| circStart | input | 32 | Start address of the circular buffer |
| accSize | input | 2 | log2 of the access size in bytes |
| effAddr | output | 32 | Effective load address |
| newPtr | output | 32 | Next pointer value (equals base when not written back) |
| wbEn | output | 1 | Pointer write-back enable |

## Verification
The bench walks the pointer through chains of accesses, so a wrong update shows up as drift in every later address. It checks that bit-reversed accesses reach offsets 0, 4, 2, 6. A unit that reversed the whole word, or put the reversed value into the pointer, would give different addresses. In the circular modes it drives the pointer across the end of the buffer and, with negative increments, below the start. A missing upper or lower correction leaves the pointer outside the buffer. A register-increment mode that ignored the size scaling, or the sign of the 7-bit field, would land at the wrong offset. It also sweeps every mode code and checks the write-back enable, so a swapped decode or an extra write-back is reported.

// File: rtl/load_agu_pkg.sv
package load_agu_pkg;

  typedef enum logic [2:0] {
    AM_OFFSET  = 3'd0,
    AM_SHIDX   = 3'd1,
    AM_ABSSET  = 3'd2,
    AM_POSTIMM = 3'd3,
    AM_POSTMOD = 3'd4,
    AM_BITREV  = 3'd5,
    AM_CIRCIMM = 3'd6,
    AM_CIRCREG = 3'd7
  } addrMode_e;

  typedef enum logic [1:0] {
    EA_BASE_IMM = 2'd0,
    EA_INDEX    = 2'd1,
    EA_ABS      = 2'd2,
    EA_BASE     = 2'd3
  } eaSel_e;

  typedef enum logic [1:0] {
    PT_IMM  = 2'd0,
    PT_MOD  = 2'd1,
    PT_CIRC = 2'd2,
    PT_ABS  = 2'd3
  } ptrSel_e;

  typedef struct packed {
    eaSel_e  eaSel;
    logic    revLow;
    ptrSel_e ptrSel;
    logic    circRegInc;
    logic    wbEn;
  } aguCtrl_t;

endpackage

// File: rtl/load_agu_ctrl.sv
module load_agu_ctrl
  import load_agu_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode,
  output aguCtrl_t          ctl
);

  always_comb begin
    ctl = '{eaSel: EA_BASE_IMM, revLow: 1'b0, ptrSel: PT_IMM,
            circRegInc: 1'b0, wbEn: 1'b0};
    case (addrMode_e'(mode))
      AM_OFFSET:  ctl.eaSel = EA_BASE_IMM;
      AM_SHIDX:   ctl.eaSel = EA_INDEX;
      AM_ABSSET: begin
        ctl.eaSel  = EA_ABS;
        ctl.ptrSel = PT_ABS;
        ctl.wbEn   = 1'b1;
      end
      AM_POSTIMM: begin
        ctl.eaSel = EA_BASE;
        ctl.wbEn  = 1'b1;
      end
      AM_POSTMOD: begin
        ctl.eaSel  = EA_BASE;
        ctl.ptrSel = PT_MOD;
        ctl.wbEn   = 1'b1;
      end
      AM_BITREV: begin
        ctl.eaSel  = EA_BASE;
        ctl.revLow = 1'b1;
        ctl.ptrSel = PT_MOD;
        ctl.wbEn   = 1'b1;
      end
      AM_CIRCIMM: begin
        ctl.eaSel  = EA_BASE;
        ctl.ptrSel = PT_CIRC;
        ctl.wbEn   = 1'b1;
      end
      AM_CIRCREG: begin
        ctl.eaSel      = EA_BASE;
        ctl.ptrSel     = PT_CIRC;
        ctl.circRegInc = 1'b1;
        ctl.wbEn       = 1'b1;
      end
      default: ;
    endcase
  end

  // Every mode that addresses through the old pointer must write it back (R10)
  always_comb begin
    if (!$isunknown(mode) && ctl.eaSel == EA_BASE)
      p_postinc_writes_r10: assert (ctl.wbEn)
        else $error("post-increment mode without write-back");
  end

endmodule

// File: rtl/load_agu_dp.sv
module load_agu_dp
  import load_agu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REV_W    = 16,
  parameter int LEN_W    = 17,
  parameter int CINC_W   = 7,
  parameter int CINC_LSB = 17,
  parameter int SHIFT_W  = 2,
  parameter int SIZE_W   = 2
) (
  input  aguCtrl_t             ctl,
  input  logic [ADDR_W-1:0]    baseReg,
  input  logic [ADDR_W-1:0]    indexReg,
  input  logic [ADDR_W-1:0]    immVal,
  input  logic [SHIFT_W-1:0]   shiftAmt,
  input  logic [ADDR_W-1:0]    modReg,
  input  logic [ADDR_W-1:0]    circStart,
  input  logic [SIZE_W-1:0]    accSize,
  output logic [ADDR_W-1:0]    effAddr,
  output logic [ADDR_W-1:0]    newPtr,
  output logic                 wbEn
);

  localparam int SUM_W = ADDR_W + 2;

  // Bit-reversed low field
  logic [REV_W-1:0] revField;
  for (genvar i = 0; i < REV_W; i++) begin : g_rev
    assign revField[i] = baseReg[REV_W-1-i];
  end
  logic [ADDR_W-1:0] revAddr;
  assign revAddr = {baseReg[ADDR_W-1:REV_W], revField};

  // Effective address select
  always_comb begin
    case (ctl.eaSel)
      EA_BASE_IMM: effAddr = baseReg + immVal;
      EA_INDEX:    effAddr = (indexReg << shiftAmt) + immVal;
      EA_ABS:      effAddr = immVal;
      default:     effAddr = ctl.revLow ? revAddr : baseReg;
    endcase
  end

  // Circular increment and wrap
  logic [LEN_W-1:0]         bufLen;
  logic [CINC_W-1:0]        regIncField;
  logic [ADDR_W-1:0]        regIncScaled;
  logic [ADDR_W-1:0]        circInc;
  logic [ADDR_W-1:0]        circOff;
  logic signed [SUM_W-1:0]  rawSum;
  logic signed [SUM_W-1:0]  lenExt;
  logic signed [SUM_W-1:0]  wrapSum;
  logic [ADDR_W-1:0]        circPtr;

  assign bufLen       = modReg[LEN_W-1:0];
  assign regIncField  = modReg[CINC_LSB+CINC_W-1:CINC_LSB];
  assign regIncScaled = {{(ADDR_W-CINC_W){regIncField[CINC_W-1]}}, regIncField} << accSize;
  assign circInc      = ctl.circRegInc ? regIncScaled : immVal;
  assign circOff      = baseReg - circStart;
  assign lenExt       = {{(SUM_W-LEN_W){1'b0}}, bufLen};
  assign rawSum       = $signed({2'b00, circOff}) + $signed({{2{circInc[ADDR_W-1]}}, circInc});

  always_comb begin
    if (rawSum < 0)            wrapSum = rawSum + lenExt;
    else if (rawSum >= lenExt) wrapSum = rawSum - lenExt;
    else                       wrapSum = rawSum;
  end
  assign circPtr = circStart + wrapSum[ADDR_W-1:0];

  // Pointer update select
  logic [ADDR_W-1:0] ptrNext;
  always_comb begin
    case (ctl.ptrSel)
      PT_IMM:  ptrNext = baseReg + immVal;
      PT_MOD:  ptrNext = baseReg + modReg;
      PT_CIRC: ptrNext = circPtr;
      default: ptrNext = immVal;
    endcase
  end

  assign newPtr = ctl.wbEn ? ptrNext : baseReg;
  assign wbEn   = ctl.wbEn;

  // Circular result stays inside the buffer for legal operands (R7, R9)
  always_comb begin
    if (!$isunknown({ctl, baseReg, immVal, modReg, circStart, accSize}) &&
        ctl.ptrSel == PT_CIRC && ctl.wbEn && bufLen != '0 &&
        circOff < ADDR_W'(bufLen) && rawSum >= -lenExt && rawSum < (lenExt + lenExt))
      p_circ_in_buffer_r9: assert ((newPtr - circStart) < ADDR_W'(bufLen))
        else $error("circular pointer left the buffer");
  end

  // Bit-reversed address: upper half kept, bit 0 taken from base bit REV_W-1 (R6)
  always_comb begin
    if (!$isunknown({ctl, baseReg}) && ctl.revLow)
      p_bitrev_fields_r6: assert (effAddr[ADDR_W-1:REV_W] == baseReg[ADDR_W-1:REV_W] &&
                                   effAddr[0] == baseReg[REV_W-1])
        else $error("bit-reversed address malformed");
  end

  // Absolute-set writes the same value it accesses (R3)
  always_comb begin
    if (!$isunknown({ctl, immVal}) && ctl.eaSel == EA_ABS)
      p_abs_match_r3: assert (effAddr == newPtr && wbEn)
        else $error("absolute-set address and pointer differ");
  end

endmodule

// File: rtl/load_agu.sv
module load_agu #(
  parameter int ADDR_W   = 32,
  parameter int MODE_W   = 3,
  parameter int REV_W    = 16,
  parameter int LEN_W    = 17,
  parameter int CINC_W   = 7,
  parameter int CINC_LSB = 17,
  parameter int SHIFT_W  = 2,
  parameter int SIZE_W   = 2
) (
  input  logic [MODE_W-1:0]  mode,
  input  logic [ADDR_W-1:0]  baseReg,
  input  logic [ADDR_W-1:0]  indexReg,
  input  logic [ADDR_W-1:0]  immVal,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic [ADDR_W-1:0]  modReg,
  input  logic [ADDR_W-1:0]  circStart,
  input  logic [SIZE_W-1:0]  accSize,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [ADDR_W-1:0]  newPtr,
  output logic               wbEn
);

  load_agu_pkg::aguCtrl_t ctl;

  load_agu_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .mode (mode),
    .ctl  (ctl)
  );

  load_agu_dp #(
    .ADDR_W(ADDR_W), .REV_W(REV_W), .LEN_W(LEN_W), .CINC_W(CINC_W),
    .CINC_LSB(CINC_LSB), .SHIFT_W(SHIFT_W), .SIZE_W(SIZE_W)
  ) u_dp (
    .ctl       (ctl),
    .baseReg   (baseReg),
    .indexReg  (indexReg),
    .immVal    (immVal),
    .shiftAmt  (shiftAmt),
    .modReg    (modReg),
    .circStart (circStart),
    .accSize   (accSize),
    .effAddr   (effAddr),
    .newPtr    (newPtr),
    .wbEn      (wbEn)
  );

endmodule

// File: tb/load_agu_test.sv
`timescale 1ns/1ps
module load_agu_test;

  typedef struct {
    string       tag;
    logic [31:0] ea;
    logic [31:0] np;
    logic        wb;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0]  mode;
  logic [31:0] baseReg, indexReg, immVal, modReg, circStart;
  logic [1:0]  shiftAmt, accSize;
  logic [31:0] effAddr, newPtr;
  logic        wbEn;

  load_agu uut (
    .mode(mode), .baseReg(baseReg), .indexReg(indexReg), .immVal(immVal),
    .shiftAmt(shiftAmt), .modReg(modReg), .circStart(circStart), .accSize(accSize),
    .effAddr(effAddr), .newPtr(newPtr), .wbEn(wbEn)
  );

  expItem_t expQ[$];
  int testCount = 0;
  int failCount = 0;
  logic [31:0] lastNp;

  function automatic expItem_t refModel(string tag, logic [2:0] m, logic [31:0] b,
      logic [31:0] idx, logic [31:0] imm, logic [1:0] sh, logic [31:0] md,
      logic [31:0] cs, logic [1:0] sz);
    expItem_t e;
    longint off, inc, len, r;
    e.tag = tag;
    e.ea  = b;
    e.np  = b;
    e.wb  = (m >= 3'd2);
    case (m)
      3'd0: e.ea = b + imm;
      3'd1: e.ea = (idx << sh) + imm;
      3'd2: begin e.ea = imm; e.np = imm; end
      3'd3: e.np = b + imm;
      3'd4: e.np = b + md;
      3'd5: begin
        for (int i = 0; i < 16; i++) e.ea[i] = b[15-i];
        e.np = b + md;
      end
      default: begin
        off = longint'(b - cs);
        len = longint'(md[16:0]);
        if (m == 3'd6) inc = longint'($signed(imm));
        else           inc = longint'($signed(md[23:17])) * (longint'(1) << sz);
        r = (off + inc) % len;
        if (r < 0) r = r + len;
        e.np = cs + 32'(r);
      end
    endcase
    return e;
  endfunction

  task automatic drive(string tag, logic [2:0] m, logic [31:0] b, logic [31:0] idx,
      logic [31:0] imm, logic [1:0] sh, logic [31:0] md, logic [31:0] cs, logic [1:0] sz);
    expItem_t e;
    @(negedge clk);
    mode = m; baseReg = b; indexReg = idx; immVal = imm; shiftAmt = sh;
    modReg = md; circStart = cs; accSize = sz;
    e = refModel(tag, m, b, idx, imm, sh, md, cs, sz);
    lastNp = e.np;
    expQ.push_back(e);
  endtask

  // Explicit constant check against a hand-computed value
  task automatic expectConst(string tag, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: outputs settle half a cycle after the negedge drive
  always @(posedge clk) begin
    if (!rst && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      testCount++;
      if (effAddr !== e.ea || newPtr !== e.np || wbEn !== e.wb) begin
        failCount++;
        $display("FAIL %s: actual ea=0x%08h np=0x%08h wb=%0b expected ea=0x%08h np=0x%08h wb=%0b",
                 e.tag, effAddr, newPtr, wbEn, e.ea, e.np, e.wb);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] p;
    logic [31:0] eaSeen [4];
    mode = '0; baseReg = '0; indexReg = '0; immVal = '0; shiftAmt = '0;
    modReg = '0; circStart = '0; accSize = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R1 offset mode
    drive("R1 offset +6", 3'd0, 32'h1000, 0, 32'd6, 0, 32'hFFFF, 0, 0);
    drive("R1 offset -4", 3'd0, 32'h1000, 0, 32'hFFFF_FFFC, 0, 0, 0, 0);
    // R2 scaled index
    drive("R2 shift 2", 3'd1, 32'h55, 32'd3, 32'h8000_0000, 2'd2, 0, 0, 0);
    drive("R2 shift 1", 3'd1, 32'h55, 32'd7, 32'h0001_0000, 2'd1, 0, 0, 0);
    drive("R2 shift 0", 3'd1, 32'h55, 32'hFFFF_FFFF, 32'd1, 2'd0, 0, 0, 0);
    // R3 absolute set
    drive("R3 absset", 3'd2, 32'h77, 0, 32'h0001_2340, 0, 0, 0, 0);
    // R4 post-increment by immediate, chained
    p = 32'h0002_0000;
    for (int k = 0; k < 4; k++) begin
      drive("R4 postimm", 3'd3, p, 0, 32'd2, 0, 0, 0, 0);
      p = lastNp;
    end
    // R5 post-increment by modifier
    drive("R5 postmod +4", 3'd4, 32'h3000, 0, 0, 0, 32'd4, 0, 0);
    drive("R5 postmod -8", 3'd4, 32'h3000, 0, 0, 0, 32'hFFFF_FFF8, 0, 0);
    // R6 bit-reversed chain from 64 KiB-aligned base
    p = 32'h0001_0000;
    for (int k = 0; k < 4; k++) begin
      drive("R6 bitrev", 3'd5, p, 0, 0, 0, 32'h2000, 0, 0);
      @(posedge clk); #1;
      eaSeen[k] = effAddr;
      p = lastNp;
    end
    expectConst("R6 offset0", eaSeen[0], 32'h0001_0000);
    expectConst("R6 offset4", eaSeen[1], 32'h0001_0004);
    expectConst("R6 offset2", eaSeen[2], 32'h0001_0002);
    expectConst("R6 offset6", eaSeen[3], 32'h0001_0006);
    // R7 circular by immediate, length 6, inc 2
    p = 32'h0004_0000;
    for (int k = 0; k < 5; k++) begin
      drive("R7 circimm", 3'd6, p, 0, 32'd2, 0, 32'd6, 32'h0004_0000, 0);
      p = lastNp;
      if (k == 2) expectConst("R7 wrap to start", lastNp, 32'h0004_0000);
    end
    // R8 circular by register: len 8, inc 2, 2-byte
    p = 32'h0005_0000;
    for (int k = 0; k < 4; k++) begin
      drive("R8 circreg", 3'd7, p, 0, 0, 0, (32'd2 << 17) | 32'd8, 32'h0005_0000, 2'd1);
      p = lastNp;
      expectConst("R8 offset", lastNp - 32'h0005_0000, (k % 2 == 0) ? 32'd4 : 32'd0);
    end
    drive("R8 circreg 8-byte", 3'd7, 32'h0006_0010, 0, 0, 0, (32'd1 << 17) | 32'd24,
          32'h0006_0000, 2'd3);
    // R9 negative increments
    drive("R9 circimm -2", 3'd6, 32'h0004_0000, 0, 32'hFFFF_FFFE, 0, 32'd6, 32'h0004_0000, 0);
    expectConst("R9 circimm -2 value", lastNp, 32'h0004_0004);
    drive("R9 circreg -1x4", 3'd7, 32'h0005_0000, 0, 0, 0, (32'h7F << 17) | 32'd8,
          32'h0005_0000, 2'd2);
    expectConst("R9 circreg value", lastNp, 32'h0005_0004);
    drive("R9 circreg no wrap", 3'd7, 32'h0005_0006, 0, 0, 0, (32'h7F << 17) | 32'd8,
          32'h0005_0000, 2'd1);
    // R10 write-back enable sweep over every mode code
    for (int m = 0; m < 8; m++) begin
      drive("R10 wb sweep", 3'(m), 32'h0007_0002, 32'd1, 32'd2, 2'd1,
            32'd6, 32'h0007_0000, 2'd0);
    end

    @(negedge clk);
    while (expQ.size() > 0) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule